// File: doc/BRIEF.md
# Buffered Synchronous Serial Transmitter

This block turns parallel words into a serial bit stream on one data line, framed by a frame-sync pulse and paced by a shift clock. Words arrive through a simple write port into a holding register. The holding register is emptied into the shift register at the start of the last bit of the word in flight, so a steady writer gets frames that follow each other with no idle bit periods. Frames can be 8, 12, 16, 20, 24 or 32 bits long. 8-bit frames can go out least-significant bit first.

All logic runs on the system clock. The shift clock is a one-cycle strobe. An internal divider produces it once every (1 + divisor) system cycles. In external mode it is taken from a synchronised edge of an external clock pin. The serial outputs update in the cycle after each strobe. The shift clock output pulses to its active level for that same cycle. Its idle level, and the inactive level of frame sync, are set by two polarity inputs.

Top module: `sertx_port`

## Requirements
- R1: The 3-bit word-length code `cfg_wlen` selects the frame length: 0 gives 8 bits, 1 gives 12, 2 gives 16, 3 gives 20, 4 gives 24 and 5 gives 32. Codes 6 and 7 give 8 bits. Only the low bits of the written word that fit the length are sent.
- R2: When the frame length is 8 and `cfg_lsb_first` is 1, bit 0 is sent first. For every other case the most significant bit of the frame is sent first, whatever `cfg_lsb_first` is.
- R3: `tx_sclk_o` rests at the level of `cfg_clk_pol`. It takes the opposite level for exactly the system cycles in which a new bit period begins.
- R4: Frame sync is active for exactly one bit period, the one immediately before the first data bit of each frame. Its inactive level equals `cfg_fs_pol`, so with `cfg_fs_pol` = 1 it is active low. It is never active during a bit period that is not the last bit of a frame or an idle period.
- R5: In internal mode (`cfg_ext_sel` = 0) with `cfg_en` = 1, bit periods last exactly `cfg_div` + 1 system cycles. A divisor of 0 gives a new bit every cycle. With `cfg_en` = 0, no bit periods start.
- R6: If the next word is already held when the last bit of a frame begins, the next frame-sync period coincides with that last bit. The next frame then follows with no idle bit period.
- R7: When a frame's last bit period ends and the next frame's first bit does not follow at once, `underflow_o` is set and stays set until reset. The data line is low in every bit period that carries no frame bit. No underflow is flagged before the first frame.
- R8: `wr_ready` is high exactly when the holding register is empty. A write accepted with `wr_ready` high drops `wr_ready` in the next cycle. A write while `wr_ready` is low is discarded and sets the sticky `overflow_o`.
- R9: In external mode (`cfg_ext_sel` = 1), a bit period begins shortly after each rising edge of `ext_sclk_i` when `cfg_clk_pol` = 0, and after each falling edge when `cfg_clk_pol` = 1.
- R10: A synchronous active-high `rst` empties both registers, clears the divider and both flags, drives `tx_data_o` low, and holds frame sync and shift clock at their inactive levels.
- R11: `tx_data_o` and `tx_fs_o` change only in cycles where a new bit period begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Enables bit-period generation |
| cfg_ext_sel | input | 1 | 1 selects the external shift clock, 0 the internal divider |
| cfg_div | input | 8 | Internal divisor; bit period is cfg_div + 1 cycles |
| cfg_wlen | input | 3 | Frame length code |
| cfg_lsb_first | input | 1 | LSB-first order for 8-bit frames |
| cfg_clk_pol | input | 1 | Shift clock idle level and external active edge |
| cfg_fs_pol | input | 1 | Frame-sync inactive level |
| ext_sclk_i | input | 1 | External shift clock |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Word to send |
| wr_ready | output | 1 | Holding register empty |
| tx_data_o | output | 1 | Serial data |
| tx_fs_o | output | 1 | Frame sync |
| tx_sclk_o | output | 1 | Shift clock strobe |
| underflow_o | output | 1 | Sticky underflow flag |
| overflow_o | output | 1 | Sticky overflow flag |

## Verification
A shift strobe seen at one clock edge shows up on data, frame sync and shift clock in the following cycle. The bench therefore samples at every falling edge and treats a shift-clock level opposite to `cfg_clk_pol` as the start of a bit period. It decodes frames from those samples alone. Both flags and `wr_ready` react one edge after their cause, so the bench checks them at the falling edge that follows. Divider periods are measured as the number of falling edges between consecutive strobes. The external path has a few cycles of synchroniser delay, so in that mode the bench checks only the frame content and ordering, not the exact edge.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

   typedef enum logic [2:0] {
      WL_8  = 3'd0,
      WL_12 = 3'd1,
      WL_16 = 3'd2,
      WL_20 = 3'd3,
      WL_24 = 3'd4,
      WL_32 = 3'd5
   } wlen_e;

   localparam int MAX_FRAME_BITS = 32;

   function automatic logic [5:0] frame_bits(input logic [2:0] code);
      logic [5:0] n;
      case (wlen_e'(code))
         WL_12:   n = 6'd12;
         WL_16:   n = 6'd16;
         WL_20:   n = 6'd20;
         WL_24:   n = 6'd24;
         WL_32:   n = 6'd32;
         default: n = 6'd8;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/sertx_clkgen.sv
module sertx_clkgen #(
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en_i,
   input  logic             ext_sel_i,
   input  logic             clk_pol_i,
   input  logic             ext_clk_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   logic [DIV_W-1:0] cnt_q;
   logic             int_tick;
   logic             ext_tick;
   logic             ext_lvl;
   logic             ext_prev_q;

   // internal divider: one strobe every div_i + 1 cycles
   always_comb int_tick = en_i && !ext_sel_i && (cnt_q >= div_i);

   always_ff @(posedge clk) begin
      if (rst || !en_i || ext_sel_i)
         cnt_q <= '0;
      else if (cnt_q >= div_i)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   // external clock: optional synchroniser chain
   generate
      if (SYNC_STAGES > 0) begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk) begin
            if (rst)
               sync_q <= '0;
            else
               sync_q <= (sync_q << 1) | SYNC_STAGES'(ext_clk_i);
         end
         assign ext_lvl = sync_q[SYNC_STAGES-1];
      end else begin : g_raw
         assign ext_lvl = ext_clk_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)
         ext_prev_q <= 1'b0;
      else
         ext_prev_q <= ext_lvl;
   end

   always_comb begin
      if (clk_pol_i)
         ext_tick = en_i && ext_sel_i && ext_prev_q && !ext_lvl;
      else
         ext_tick = en_i && ext_sel_i && !ext_prev_q && ext_lvl;
   end

   assign tick_o = int_tick || ext_tick;

endmodule

// File: rtl/sertx_holdbuf.sv
module sertx_holdbuf #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              take_i,
   output logic              full_o,
   output logic [DATA_W-1:0] word_o,
   output logic              overflow_o
);

   logic              full_q;
   logic [DATA_W-1:0] word_q;
   logic              ovf_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         full_q <= 1'b0;
         word_q <= '0;
         ovf_q  <= 1'b0;
      end else begin
         if (wr_en_i && !full_q) begin
            full_q <= 1'b1;
            word_q <= wr_data_i;
         end else if (take_i) begin
            full_q <= 1'b0;
         end
         if (wr_en_i && full_q)
            ovf_q <= 1'b1;
      end
   end

   assign full_o     = full_q;
   assign word_o     = word_q;
   assign overflow_o = ovf_q;

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
   import sertx_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick_i,
   input  logic              hold_full_i,
   input  logic [DATA_W-1:0] hold_word_i,
   input  logic [2:0]        wlen_i,
   input  logic              lsb_first_i,
   output logic              take_o,
   output logic              data_o,
   output logic              fs_o,
   output logic              strobe_o,
   output logic              underflow_o
);

   localparam int LEN_W = $clog2(DATA_W + 1);

   logic [DATA_W-1:0] sh_q;
   logic [LEN_W-1:0]  rem_q;
   logic [LEN_W-1:0]  len_q;
   logic              lsb_q;
   logic              prim_q;
   logic              last_q;
   logic              data_q;
   logic              fs_q;
   logic              strobe_q;
   logic              unf_q;

   logic [LEN_W-1:0]  len_new;
   logic              lsb_new;
   logic [LEN_W-1:0]  rem_after;
   logic              sending;
   logic              out_bit;
   logic [DATA_W-1:0] aligned;

   always_comb begin
      len_new = LEN_W'(frame_bits(wlen_i));
      lsb_new = lsb_first_i && (len_new == LEN_W'(8));
      sending = prim_q || (rem_q != '0);
      if (prim_q)
         rem_after = len_q - 1'b1;
      else if (rem_q != '0)
         rem_after = rem_q - 1'b1;
      else
         rem_after = '0;
      take_o  = tick_i && hold_full_i && (rem_after == '0);
      out_bit = lsb_q ? sh_q[0] : sh_q[DATA_W-1];
      // MSB-first frames are left-justified so the top bit leaves first
      if (lsb_new)
         aligned = hold_word_i;
      else
         aligned = hold_word_i << (DATA_W - int'(len_new));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q     <= '0;
         rem_q    <= '0;
         len_q    <= '0;
         lsb_q    <= 1'b0;
         prim_q   <= 1'b0;
         last_q   <= 1'b0;
         data_q   <= 1'b0;
         fs_q     <= 1'b0;
         strobe_q <= 1'b0;
         unf_q    <= 1'b0;
      end else begin
         strobe_q <= tick_i;
         if (tick_i) begin
            data_q <= sending ? out_bit : 1'b0;
            rem_q  <= rem_after;
            last_q <= sending && (rem_after == '0);
            prim_q <= 1'b0;
            fs_q   <= 1'b0;
            sh_q   <= lsb_q ? (sh_q >> 1) : (sh_q << 1);
            if (last_q && !prim_q)
               unf_q <= 1'b1;
            if (take_o) begin
               sh_q   <= aligned;
               len_q  <= len_new;
               lsb_q  <= lsb_new;
               prim_q <= 1'b1;
               fs_q   <= 1'b1;
            end
         end
      end
   end

   assign data_o      = data_q;
   assign fs_o        = fs_q;
   assign strobe_o    = strobe_q;
   assign underflow_o = unf_q;

endmodule

// File: rtl/sertx_port.sv
module sertx_port
   import sertx_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_en,
   input  logic              cfg_ext_sel,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic [2:0]        cfg_wlen,
   input  logic              cfg_lsb_first,
   input  logic              cfg_clk_pol,
   input  logic              cfg_fs_pol,
   input  logic              ext_sclk_i,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   output logic              tx_data_o,
   output logic              tx_fs_o,
   output logic              tx_sclk_o,
   output logic              underflow_o,
   output logic              overflow_o
);

   generate
      if (DATA_W < MAX_FRAME_BITS) begin : g_bad_width
         $error("sertx_port: DATA_W must cover the longest frame");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("sertx_port: DIV_W must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("sertx_port: SYNC_STAGES must not be negative");
      end
   endgenerate

   logic              shift_tick;
   logic              take;
   logic              hold_full;
   logic [DATA_W-1:0] hold_word;
   logic              fs_act;
   logic              strobe;

   sertx_clkgen #(
      .DIV_W       (DIV_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_clkgen (
      .clk       (clk),
      .rst       (rst),
      .en_i      (cfg_en),
      .ext_sel_i (cfg_ext_sel),
      .clk_pol_i (cfg_clk_pol),
      .ext_clk_i (ext_sclk_i),
      .div_i     (cfg_div),
      .tick_o    (shift_tick)
   );

   sertx_holdbuf #(
      .DATA_W (DATA_W)
   ) u_hold (
      .clk        (clk),
      .rst        (rst),
      .wr_en_i    (wr_en),
      .wr_data_i  (wr_data),
      .take_i     (take),
      .full_o     (hold_full),
      .word_o     (hold_word),
      .overflow_o (overflow_o)
   );

   sertx_shifter #(
      .DATA_W (DATA_W)
   ) u_shift (
      .clk         (clk),
      .rst         (rst),
      .tick_i      (shift_tick),
      .hold_full_i (hold_full),
      .hold_word_i (hold_word),
      .wlen_i      (cfg_wlen),
      .lsb_first_i (cfg_lsb_first),
      .take_o      (take),
      .data_o      (tx_data_o),
      .fs_o        (fs_act),
      .strobe_o    (strobe),
      .underflow_o (underflow_o)
   );

   assign wr_ready  = !hold_full;
   assign tx_fs_o   = fs_act ^ cfg_fs_pol;
   assign tx_sclk_o = strobe ^ cfg_clk_pol;

endmodule

// File: rtl/sertx_port_chk.sv
module sertx_port_chk (
   input logic clk,
   input logic rst,
   input logic wr_en,
   input logic wr_ready,
   input logic shift_tick,
   input logic cfg_clk_pol,
   input logic tx_data_o,
   input logic tx_fs_o,
   input logic tx_sclk_o,
   input logic underflow_o,
   input logic overflow_o
);

   a_r8_blocked_write_flags: assert property (@(posedge clk) disable iff (rst)
      wr_en && !wr_ready |=> overflow_o);

   a_r8_accept_drops_ready: assert property (@(posedge clk) disable iff (rst)
      wr_en && wr_ready |=> !wr_ready);

   a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
      overflow_o |=> overflow_o);

   a_r7_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
      underflow_o |=> underflow_o);

   a_r10_reset_state: assert property (@(posedge clk)
      rst |=> (!underflow_o && !overflow_o && wr_ready && !tx_data_o));

   a_r11_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
      !shift_tick |=> ($stable(tx_data_o) && $stable(tx_fs_o)));

   a_r3_sclk_idle_level: assert property (@(posedge clk) disable iff (rst)
      !shift_tick |=> (tx_sclk_o == cfg_clk_pol));

endmodule

bind sertx_port sertx_port_chk u_chk (
   .clk         (clk),
   .rst         (rst),
   .wr_en       (wr_en),
   .wr_ready    (wr_ready),
   .shift_tick  (shift_tick),
   .cfg_clk_pol (cfg_clk_pol),
   .tx_data_o   (tx_data_o),
   .tx_fs_o     (tx_fs_o),
   .tx_sclk_o   (tx_sclk_o),
   .underflow_o (underflow_o),
   .overflow_o  (overflow_o)
);

// File: tb/sertx_port_tb.sv
`timescale 1ns/1ps
module sertx_port_tb_top;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_en = 1'b1;
   logic        cfg_ext_sel = 1'b0;
   logic [7:0]  cfg_div = 8'd0;
   logic [2:0]  cfg_wlen = 3'd0;
   logic        cfg_lsb_first = 1'b0;
   logic        cfg_clk_pol = 1'b0;
   logic        cfg_fs_pol = 1'b0;
   logic        ext_sclk_i = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        wr_ready, tx_data_o, tx_fs_o, tx_sclk_o, underflow_o, overflow_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit finished = 0;
   bit ext_run = 0;
   int standalone_fs = 0;
   logic [31:0] exp_q[$];

   always #4 clk = ~clk;

   sertx_port dut_i (
      .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_ext_sel(cfg_ext_sel),
      .cfg_div(cfg_div), .cfg_wlen(cfg_wlen), .cfg_lsb_first(cfg_lsb_first),
      .cfg_clk_pol(cfg_clk_pol), .cfg_fs_pol(cfg_fs_pol), .ext_sclk_i(ext_sclk_i),
      .wr_en(wr_en), .wr_data(wr_data), .wr_ready(wr_ready), .tx_data_o(tx_data_o),
      .tx_fs_o(tx_fs_o), .tx_sclk_o(tx_sclk_o), .underflow_o(underflow_o),
      .overflow_o(overflow_o)
   );

   function automatic int bench_len(input logic [2:0] code);
      case (code)
         3'd1: return 12;
         3'd2: return 16;
         3'd3: return 20;
         3'd4: return 24;
         3'd5: return 32;
         default: return 8;
      endcase
   endfunction

   function automatic logic [31:0] len_mask(input int n);
      if (n >= 32) return 32'hFFFF_FFFF;
      return (32'h1 << n) - 32'h1;
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary_and_end();
      if (!finished) begin
         finished = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc == 190000 && !finished) begin
         errors++;
         $display("FAIL R10 watchdog actual %0d cycles expected fewer", cyc);
         summary_and_end();
      end
   end

   // external clock source, period of six system cycles
   initial begin
      int ph = 0;
      forever begin
         @(negedge clk);
         ph++;
         if (ext_run && (ph % 3 == 0)) ext_sclk_i = ~ext_sclk_i;
      end
   end

   // serial monitor and frame decoder
   logic        mon_pend = 0;
   int          mon_left = 0;
   int          mon_idx = 0;
   logic [31:0] mon_word = '0;
   logic        prev_data = 0, prev_fs = 0;

   always @(negedge clk) begin
      bit tick_now, fs_act, mlsb;
      int mlen;
      logic [31:0] e;
      if (rst) begin
         mon_pend = 0;
         mon_left = 0;
      end else begin
         tick_now = (tx_sclk_o != cfg_clk_pol);
         fs_act   = (tx_fs_o != cfg_fs_pol);
         mlen     = bench_len(cfg_wlen);
         mlsb     = cfg_lsb_first && (mlen == 8);
         if (!tick_now) begin
            chk(tx_data_o == prev_data && tx_fs_o == prev_fs, "R11 outputs moved without shift",
                {tx_data_o, tx_fs_o}, {prev_data, prev_fs});
         end else begin
            if (mon_pend) begin
               mon_left = mlen; mon_pend = 0; mon_word = '0; mon_idx = 0;
            end
            if (mon_left > 0) begin
               if (mlsb) mon_word[mon_idx] = tx_data_o;
               else      mon_word = {mon_word[30:0], tx_data_o};
               mon_idx++;
               mon_left--;
               if (mon_left == 0) begin
                  if (exp_q.size() == 0) begin
                     chk(0, "R8 R6 unexpected frame", mon_word, 0);
                  end else begin
                     e = exp_q.pop_front();
                     chk(mon_word == e, "R1 R2 frame content", mon_word, e);
                  end
               end
            end else begin
               chk(tx_data_o == 1'b0, "R7 idle data low", tx_data_o, 0);
               if (fs_act) standalone_fs++;
            end
            if (fs_act) begin
               chk(mon_left == 0, "R4 frame sync inside frame", mon_left, 0);
               mon_pend = 1;
            end
         end
      end
      prev_data = tx_data_o;
      prev_fs   = tx_fs_o;
   end

   task automatic apply_reset(input logic [7:0] d, input logic [2:0] code, input bit lsb,
                              input bit cp, input bit fp, input bit ext);
      @(negedge clk);
      rst = 1;
      ext_run = 0;
      @(negedge clk);
      cfg_div = d; cfg_wlen = code; cfg_lsb_first = lsb;
      cfg_clk_pol = cp; cfg_fs_pol = fp; cfg_ext_sel = ext; cfg_en = 1;
      ext_sclk_i = 0;
      exp_q.delete();
      repeat (2) @(negedge clk);
      chk(wr_ready && !tx_data_o && !underflow_o && !overflow_o, "R10 reset state",
          {wr_ready, tx_data_o, underflow_o, overflow_o}, 4'b1000);
      chk(tx_fs_o == fp && tx_sclk_o == cp, "R10 R3 R4 reset levels",
          {tx_fs_o, tx_sclk_o}, {fp, cp});
      rst = 0;
      standalone_fs = 0;
      ext_run = ext;
   endtask

   task automatic send(input logic [31:0] w);
      int n = bench_len(cfg_wlen);
      @(negedge clk);
      while (!wr_ready) @(negedge clk);
      wr_en = 1; wr_data = w;
      exp_q.push_back(w & len_mask(n));
      @(negedge clk);
      wr_en = 0;
      chk(!wr_ready, "R8 ready falls after write", wr_ready, 0);
   endtask

   task automatic drain(input int tail);
      int t = 0;
      while (exp_q.size() != 0 && t < 60000) begin
         @(negedge clk);
         t++;
      end
      chk(exp_q.size() == 0, "R6 all frames sent", exp_q.size(), 0);
      repeat (tail) @(negedge clk);
   endtask

   task automatic segment(input int n, input logic [7:0] d, input logic [2:0] code,
                          input bit lsb, input bit cp, input bit fp, input bit ext);
      apply_reset(d, code, lsb, cp, fp, ext);
      for (int i = 0; i < n; i++) send($urandom());
      drain(ext ? 30 : 3 * (int'(d) + 1) + 4);
      chk(standalone_fs == 1, "R6 frames back to back", standalone_fs, 1);
      chk(underflow_o == 1'b1, "R7 underflow after last frame", underflow_o, 1);
      chk(tx_data_o == 1'b0, "R7 data low after underflow", tx_data_o, 0);
      chk(overflow_o == 1'b0, "R8 no overflow when paced", overflow_o, 0);
   endtask

   task automatic measure_period(input logic [7:0] d);
      int cnt;
      apply_reset(d, 3'd0, 0, 1, 0, 0);
      for (int k = 0; k < 2; k++) begin
         do @(negedge clk); while (tx_sclk_o == cfg_clk_pol);
         cnt = 0;
         do begin @(negedge clk); cnt++; end while (tx_sclk_o == cfg_clk_pol && cnt < 400);
         chk(cnt == int'(d) + 1, "R5 bit period", cnt, int'(d) + 1);
      end
   endtask

   initial begin
      void'($urandom(32'h5EED_2024));
      repeat (3) @(negedge clk);

      // idle from reset: no underflow, no frames
      apply_reset(8'd2, 3'd0, 0, 0, 0, 0);
      repeat (40) @(negedge clk);
      chk(!underflow_o && wr_ready && !tx_data_o, "R7 no underflow before first frame",
          {underflow_o, wr_ready, tx_data_o}, 3'b010);

      // divider periods
      measure_period(8'd0);
      measure_period(8'd1);
      measure_period(8'd4);
      measure_period(8'd255);

      // enable low: no bit periods
      apply_reset(8'd1, 3'd0, 0, 0, 0, 0);
      cfg_en = 0;
      send(32'hA5);
      begin
         int pulses = 0;
         for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (tx_sclk_o != cfg_clk_pol) pulses++;
         end
         chk(pulses == 0, "R5 disabled divider", pulses, 0);
      end
      cfg_en = 1;
      drain(10);

      // every length code, both orders, codes 6 and 7 fall back to 8 bits
      for (int c = 0; c < 8; c++) segment(3, 8'd1, 3'(c), 0, 0, 0, 0);
      segment(3, 8'd0, 3'd0, 1, 0, 1, 0);   // R2 LSB first on 8-bit
      segment(3, 8'd2, 3'd7, 1, 1, 0, 0);   // R1 R2 fallback code with LSB first
      segment(3, 8'd1, 3'd2, 1, 0, 0, 0);   // R2 order bit ignored for 16 bits
      segment(2, 8'd0, 3'd5, 1, 1, 1, 0);   // R2 order bit ignored for 32 bits

      // overflow: third write while holding register is full
      apply_reset(8'd7, 3'd0, 0, 0, 0, 0);
      send(32'h3C);
      send(32'hC3);
      chk(overflow_o == 1'b0, "R8 no overflow yet", overflow_o, 0);
      @(negedge clk);
      wr_en = 1; wr_data = 32'h99;
      @(negedge clk);
      wr_en = 0;
      chk(overflow_o == 1'b1, "R8 overflow on blocked write", overflow_o, 1);
      chk(wr_ready == 1'b0, "R8 ready stays low", wr_ready, 0);
      drain(40);

      // external shift clock, both edges
      segment(3, 8'd0, 3'd1, 0, 0, 0, 1);   // R9 rising edges
      segment(3, 8'd0, 3'd0, 1, 1, 1, 1);   // R9 falling edges

      // constrained random segments
      for (int s = 0; s < 14; s++) begin
         segment($urandom_range(2, 5), 8'($urandom_range(0, 6)), 3'($urandom_range(0, 7)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 0);
      end

      summary_and_end();
   end

endmodule